// File: doc/BRIEF.md
# Raster Timing Generator with Character-Clock Horizontal Counting

This block produces the horizontal and vertical raster timing for one display head. It counts pixels in groups of eight (one character clock) along each line and counts scanlines down the frame. From these counts it drives the sync pulses, the blanking intervals, a display-enable strobe, the current raster position and a once-per-frame line-compare pulse. The timing values use a compact, offset-encoded register format. Totals and end values carry fixed offsets from the true counts. Blank end and sync end are matched only against the low bits of the running counter, which limits how wide those pulses can be.

The configuration inputs are sampled into a shadow copy on the clock edge that ends a frame, and during reset. This lets a host change any timing field at any moment without producing a torn frame. Polarity, sync-disable and screen-off controls are shadowed the same way. Screen-off blanks the picture while the counters and sync pulses keep running, so an attached monitor stays locked.

Top module: `crtc_timing_gen`

## Requirements
- R1: One line is `cfg_htotal + 5` characters of 8 pixels each. `pix_col` equals character × 8 + pixel-within-character and steps by one per clock. The frame is `cfg_vtotal + 2` lines. `pix_line` advances only as `pix_col` wraps to 0, and the raster wraps to (0,0) after the last pixel of the last line.
- R2: Horizontal blanking starts at character `cfg_hblank_start + 1`. It ends after the first character whose low 6 bits equal `cfg_hblank_end`.
- R3: The horizontal sync pulse starts at character `cfg_hsync_start`. It ends at the first later character whose low 5 bits equal `cfg_hsync_end`, so its width is (`cfg_hsync_end` − `cfg_hsync_start`) mod 32 characters. Sync changes only on a character boundary.
- R4: Vertical blanking starts at line `cfg_vblank_start + 1`. It ends after the first line whose low 8 bits equal `cfg_vblank_end`.
- R5: The vertical sync pulse starts at line `cfg_vsync_start`. It ends at the first later line whose low 4 bits equal `cfg_vsync_end`, giving a width of (`cfg_vsync_end` − `cfg_vsync_start`) mod 16 lines. Vertical sync changes only while `pix_col` is 0.
- R6: When `cfg_hsync_neg` (`cfg_vsync_neg`) is 1, `hsync` (`vsync`) is active low and idles high. When it is 0, the output is active high.
- R7: When `cfg_hsync_off` (`cfg_vsync_off`) is 1, `hsync` (`vsync`) is held at its inactive level for the whole frame.
- R8: When `cfg_screen_off` is 1, `hblank` and `vblank` are both 1 and `disp_en` is 0. Raster position and sync pulses continue unchanged.
- R9: `disp_en` is 1 exactly when neither blank is active, the character is at most `cfg_hdisp_end` and the line is at most `cfg_vdisp_end`.
- R10: `line_cmp_hit` is 1 for exactly one clock per frame: the first pixel (`pix_col` = 0) of line `cfg_line_cmp`.
- R11: While `rst_n` is low at a clock edge, both counters return to 0. Both sync outputs go to their inactive level and both blanks are 0.
- R12: Configuration inputs take effect at the first pixel of the frame that follows their change. The frame in progress completes with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_htotal | input | 9 | Line length in characters minus 5 |
| cfg_hdisp_end | input | 9 | Last visible character (count minus 1) |
| cfg_hblank_start | input | 9 | Last character before horizontal blanking |
| cfg_hblank_end | input | 6 | Low-6-bit match for the last blanked character |
| cfg_hsync_start | input | 9 | First character of horizontal sync |
| cfg_hsync_end | input | 5 | Low-5-bit match for the first character after sync |
| cfg_vtotal | input | 12 | Frame length in lines minus 2 |
| cfg_vdisp_end | input | 12 | Last visible line (count minus 1) |
| cfg_vblank_start | input | 12 | Last line before vertical blanking |
| cfg_vblank_end | input | 8 | Low-8-bit match for the last blanked line |
| cfg_vsync_start | input | 12 | First line of vertical sync |
| cfg_vsync_end | input | 4 | Low-4-bit match for the first line after sync |
| cfg_line_cmp | input | 12 | Line that raises the compare pulse |
| cfg_hsync_neg | input | 1 | 1 makes hsync active low |
| cfg_vsync_neg | input | 1 | 1 makes vsync active low |
| cfg_hsync_off | input | 1 | 1 holds hsync inactive |
| cfg_vsync_off | input | 1 | 1 holds vsync inactive |
| cfg_screen_off | input | 1 | 1 forces blanking, timing keeps running |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| disp_en | output | 1 | Visible pixel strobe |
| pix_col | output | 13 | Current pixel column |
| pix_line | output | 13 | Current scanline |
| line_cmp_hit | output | 1 | One-clock pulse at the compare line |

## Verification
Several properties are checked on every cycle. These are the unit step of the column counter, line changes only at column 0, and sync edges only on character boundaries (vertical ones only at column 0). Also checked are display-enable excluding both blanks, the single-clock compare pulse, and the counters returning to zero under reset. Other behaviour depends on the programmed values, so only the bench's frame sweeps can show it. This covers the exact window positions produced by the low-bit end matches, including a sync pulse whose end value wraps below its start and a blank that ends mid-line or mid-frame. It also covers the polarity, disable and screen-off levels, and the deferral of a mid-frame register change to the next frame boundary.

// File: rtl/crtc_pkg.sv
// Package: crtc_pkg
// Shared encoding widths and the control-bit bundle for the raster timing
// generator. The partial-match widths are fixed by the register encoding and
// are not meant to be changed per instance.
package crtc_pkg;

    localparam int HBE_W = 6;   // horizontal blank-end match width
    localparam int HSE_W = 5;   // horizontal sync-end match width
    localparam int VBE_W = 8;   // vertical blank-end match width
    localparam int VSE_W = 4;   // vertical sync-end match width

    localparam int H_TOTAL_OFS = 5;   // characters added to the horizontal total field
    localparam int V_TOTAL_OFS = 2;   // lines added to the vertical total field

    typedef struct packed {
        logic hsync_neg;
        logic vsync_neg;
        logic hsync_off;
        logic vsync_off;
        logic screen_off;
    } crtc_ctl_t;

    localparam int CTL_W = $bits(crtc_ctl_t);

endpackage

// File: rtl/crtc_shadow.sv
// Module: crtc_shadow
// Holds the working copy of the timing configuration. The copy follows the
// inputs while reset is asserted and is reloaded only when load is high
// (the last pixel of a frame), so a frame never mixes old and new values.
// Assumes the inputs are stable around the loading edge.
module crtc_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture the configuration during reset and at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/crtc_hgen.sv
// Module: crtc_hgen
// Horizontal half of the raster: a pixel-within-character counter and a
// character counter, plus the horizontal blank and sync state flags.
// The line holds htotal + H_TOTAL_OFS characters. Blank and sync are kept as
// set/clear flags because their end values match only low counter bits.
// Assumes CHAR_W >= 2 and HREG_W >= HBE_W.
module crtc_hgen
    import crtc_pkg::*;
#(
    parameter int HREG_W = 9,
    parameter int CHAR_W = 8,
    localparam int HC_W  = HREG_W + 1,
    localparam int PB_W  = $clog2(CHAR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HREG_W-1:0] htotal,
    input  logic [HREG_W-1:0] hblank_start,
    input  logic [HBE_W-1:0]  hblank_end,
    input  logic [HREG_W-1:0] hsync_start,
    input  logic [HSE_W-1:0]  hsync_end,
    output logic [HC_W-1:0]   char_cnt,
    output logic [PB_W-1:0]   pix_cnt,
    output logic              char_end,
    output logic              line_end,
    output logic              hblank_flag,
    output logic              hsync_flag
);

    localparam logic [PB_W-1:0] PIX_LAST = PB_W'(CHAR_W - 1);

    logic [HC_W-1:0] last_char;
    logic [HC_W-1:0] next_char;
    logic [HC_W-1:0] blank_first;
    logic [HC_W-1:0] sync_first;

    // Decode the last character of the line and the next character index.
    always_comb begin
        last_char   = HC_W'(htotal) + HC_W'(H_TOTAL_OFS - 1);
        blank_first = HC_W'(hblank_start) + HC_W'(1);
        sync_first  = HC_W'(hsync_start);
        char_end    = (pix_cnt == PIX_LAST);
        line_end    = char_end && (char_cnt == last_char);
        next_char   = line_end ? '0 : char_cnt + HC_W'(1);
    end

    // Advance the pixel and character counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_cnt  <= '0;
            char_cnt <= '0;
        end else begin
            pix_cnt <= char_end ? '0 : pix_cnt + PB_W'(1);
            if (char_end) begin
                char_cnt <= next_char;
            end
        end
    end

    // Horizontal blank: set on entering the first blanked character, cleared
    // after the character whose low bits match the end field (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hblank_flag <= 1'b0;
        end else if (char_end) begin
            if (next_char == blank_first) begin
                hblank_flag <= 1'b1;
            end else if (char_cnt[HBE_W-1:0] == hblank_end) begin
                hblank_flag <= 1'b0;
            end
        end
    end

    // Horizontal sync: set on entering the start character, cleared on
    // entering the first character whose low bits match the end field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_flag <= 1'b0;
        end else if (char_end) begin
            if (next_char == sync_first) begin
                hsync_flag <= 1'b1;
            end else if (next_char[HSE_W-1:0] == hsync_end) begin
                hsync_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/crtc_vgen.sv
// Module: crtc_vgen
// Vertical half of the raster: the scanline counter and the vertical blank
// and sync flags, all stepped by the line-end strobe of the horizontal half.
// The frame holds vtotal + V_TOTAL_OFS lines. Assumes VREG_W >= VBE_W.
module crtc_vgen
    import crtc_pkg::*;
#(
    parameter int VREG_W = 12,
    localparam int VC_W  = VREG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic [VREG_W-1:0] vtotal,
    input  logic [VREG_W-1:0] vblank_start,
    input  logic [VBE_W-1:0]  vblank_end,
    input  logic [VREG_W-1:0] vsync_start,
    input  logic [VSE_W-1:0]  vsync_end,
    output logic [VC_W-1:0]   line_cnt,
    output logic              frame_end,
    output logic              vblank_flag,
    output logic              vsync_flag
);

    logic [VC_W-1:0] last_line;
    logic [VC_W-1:0] next_line;
    logic [VC_W-1:0] blank_first;
    logic [VC_W-1:0] sync_first;

    // Decode the last line of the frame and the next line index.
    always_comb begin
        last_line   = VC_W'(vtotal) + VC_W'(V_TOTAL_OFS - 1);
        blank_first = VC_W'(vblank_start) + VC_W'(1);
        sync_first  = VC_W'(vsync_start);
        frame_end   = line_end && (line_cnt == last_line);
        next_line   = frame_end ? '0 : line_cnt + VC_W'(1);
    end

    // Advance the scanline counter at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
        end else if (line_end) begin
            line_cnt <= next_line;
        end
    end

    // Vertical blank: set entering the first blanked line, cleared after the
    // line whose low bits match the end field (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vblank_flag <= 1'b0;
        end else if (line_end) begin
            if (next_line == blank_first) begin
                vblank_flag <= 1'b1;
            end else if (line_cnt[VBE_W-1:0] == vblank_end) begin
                vblank_flag <= 1'b0;
            end
        end
    end

    // Vertical sync: set entering the start line, cleared entering the first
    // line whose low bits match the end field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsync_flag <= 1'b0;
        end else if (line_end) begin
            if (next_line == sync_first) begin
                vsync_flag <= 1'b1;
            end else if (next_line[VSE_W-1:0] == vsync_end) begin
                vsync_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/crtc_timing_gen.sv
// Module: crtc_timing_gen
// Raster timing generator for one display head. Shadows the configuration at
// frame boundaries, runs the horizontal and vertical generators, and applies
// polarity, sync-disable and screen-off to form the outputs. All outputs
// are decoded from registered state and align with pix_col / pix_line.
// Assumes a continuously running pixel clock.
module crtc_timing_gen
    import crtc_pkg::*;
#(
    parameter int HREG_W = 9,
    parameter int VREG_W = 12,
    parameter int CHAR_W = 8,
    localparam int HC_W  = HREG_W + 1,
    localparam int VC_W  = VREG_W + 1,
    localparam int PB_W  = $clog2(CHAR_W),
    localparam int COL_W = HC_W + PB_W,
    localparam int LINE_W = VC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HREG_W-1:0] cfg_htotal,
    input  logic [HREG_W-1:0] cfg_hdisp_end,
    input  logic [HREG_W-1:0] cfg_hblank_start,
    input  logic [HBE_W-1:0]  cfg_hblank_end,
    input  logic [HREG_W-1:0] cfg_hsync_start,
    input  logic [HSE_W-1:0]  cfg_hsync_end,
    input  logic [VREG_W-1:0] cfg_vtotal,
    input  logic [VREG_W-1:0] cfg_vdisp_end,
    input  logic [VREG_W-1:0] cfg_vblank_start,
    input  logic [VBE_W-1:0]  cfg_vblank_end,
    input  logic [VREG_W-1:0] cfg_vsync_start,
    input  logic [VSE_W-1:0]  cfg_vsync_end,
    input  logic [VREG_W-1:0] cfg_line_cmp,
    input  logic              cfg_hsync_neg,
    input  logic              cfg_vsync_neg,
    input  logic              cfg_hsync_off,
    input  logic              cfg_vsync_off,
    input  logic              cfg_screen_off,
    output logic              hsync,
    output logic              vsync,
    output logic              hblank,
    output logic              vblank,
    output logic              disp_en,
    output logic [COL_W-1:0]  pix_col,
    output logic [LINE_W-1:0] pix_line,
    output logic              line_cmp_hit
);

    localparam int SH_W = 4 * HREG_W + HBE_W + HSE_W
                        + 5 * VREG_W + VBE_W + VSE_W + CTL_W;

    crtc_ctl_t         ctl_in;
    crtc_ctl_t         s_ctl;
    logic [SH_W-1:0]   sh_d;
    logic [SH_W-1:0]   sh_q;

    logic [HREG_W-1:0] s_htotal, s_hdisp_end, s_hblank_start, s_hsync_start;
    logic [HBE_W-1:0]  s_hblank_end;
    logic [HSE_W-1:0]  s_hsync_end;
    logic [VREG_W-1:0] s_vtotal, s_vdisp_end, s_vblank_start, s_vsync_start, s_line_cmp;
    logic [VBE_W-1:0]  s_vblank_end;
    logic [VSE_W-1:0]  s_vsync_end;

    logic [HC_W-1:0]   char_cnt;
    logic [PB_W-1:0]   pix_cnt;
    logic [VC_W-1:0]   line_cnt;
    logic              char_end;
    logic              line_end;
    logic              frame_end;
    logic              hb_flag, hs_flag, vb_flag, vs_flag;
    logic              in_h_area, in_v_area;

    // Bundle the control bits.
    always_comb begin
        ctl_in.hsync_neg  = cfg_hsync_neg;
        ctl_in.vsync_neg  = cfg_vsync_neg;
        ctl_in.hsync_off  = cfg_hsync_off;
        ctl_in.vsync_off  = cfg_vsync_off;
        ctl_in.screen_off = cfg_screen_off;
    end

    assign sh_d = {cfg_htotal, cfg_hdisp_end, cfg_hblank_start, cfg_hsync_start,
                   cfg_hblank_end, cfg_hsync_end,
                   cfg_vtotal, cfg_vdisp_end, cfg_vblank_start, cfg_vsync_start,
                   cfg_line_cmp, cfg_vblank_end, cfg_vsync_end, ctl_in};

    assign {s_htotal, s_hdisp_end, s_hblank_start, s_hsync_start,
            s_hblank_end, s_hsync_end,
            s_vtotal, s_vdisp_end, s_vblank_start, s_vsync_start,
            s_line_cmp, s_vblank_end, s_vsync_end, s_ctl} = sh_q;

    crtc_shadow #(
        .W (SH_W)
    ) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_end),
        .d     (sh_d),
        .q     (sh_q)
    );

    crtc_hgen #(
        .HREG_W (HREG_W),
        .CHAR_W (CHAR_W)
    ) u_hgen (
        .clk          (clk),
        .rst_n        (rst_n),
        .htotal       (s_htotal),
        .hblank_start (s_hblank_start),
        .hblank_end   (s_hblank_end),
        .hsync_start  (s_hsync_start),
        .hsync_end    (s_hsync_end),
        .char_cnt     (char_cnt),
        .pix_cnt      (pix_cnt),
        .char_end     (char_end),
        .line_end     (line_end),
        .hblank_flag  (hb_flag),
        .hsync_flag   (hs_flag)
    );

    crtc_vgen #(
        .VREG_W (VREG_W)
    ) u_vgen (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_end     (line_end),
        .vtotal       (s_vtotal),
        .vblank_start (s_vblank_start),
        .vblank_end   (s_vblank_end),
        .vsync_start  (s_vsync_start),
        .vsync_end    (s_vsync_end),
        .line_cnt     (line_cnt),
        .frame_end    (frame_end),
        .vblank_flag  (vb_flag),
        .vsync_flag   (vs_flag)
    );

    // Form the outputs from the flags and the shadowed control bits.
    always_comb begin
        in_h_area    = (char_cnt <= HC_W'(s_hdisp_end));
        in_v_area    = (line_cnt <= VC_W'(s_vdisp_end));
        hblank       = hb_flag | s_ctl.screen_off;
        vblank       = vb_flag | s_ctl.screen_off;
        disp_en      = !hblank && !vblank && in_h_area && in_v_area;
        hsync        = (hs_flag & ~s_ctl.hsync_off) ^ s_ctl.hsync_neg;
        vsync        = (vs_flag & ~s_ctl.vsync_off) ^ s_ctl.vsync_neg;
        pix_col      = COL_W'(char_cnt) * COL_W'(CHAR_W) + COL_W'(pix_cnt);
        pix_line     = line_cnt;
        line_cmp_hit = (line_cnt == VC_W'(s_line_cmp)) && (char_cnt == '0) && (pix_cnt == '0);
    end

endmodule

// File: rtl/crtc_timing_gen_chk.sv
// Module: crtc_timing_gen_chk
// Cycle-by-cycle properties of the raster timing generator, observed at its
// ports only. Attached to every instance of the top module by the bind below.
module crtc_timing_gen_chk #(
    parameter int COL_W  = 13,
    parameter int LINE_W = 13,
    parameter int CHAR_W = 8,
    localparam int PB_W  = $clog2(CHAR_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hsync,
    input logic              vsync,
    input logic              hblank,
    input logic              vblank,
    input logic              disp_en,
    input logic [COL_W-1:0]  pix_col,
    input logic [LINE_W-1:0] pix_line,
    input logic              line_cmp_hit
);

    // R1: the column steps by one unless it has wrapped to zero.
    assert_col_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pix_col != '0) |-> (pix_col == $past(pix_col) + COL_W'(1)));

    // R1: the line changes only as the column wraps.
    assert_line_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pix_line != $past(pix_line)) |-> (pix_col == '0));

    // R3: horizontal sync edges fall on character boundaries.
    assert_hsync_char_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(hsync)) |-> (pix_col[PB_W-1:0] == '0));

    // R5: vertical sync edges fall at the start of a line.
    assert_vsync_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(vsync)) |-> (pix_col == '0));

    // R9: no visible pixel during either blank.
    assert_de_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> (!hblank && !vblank));

    // R10: the compare pulse is one clock wide and sits at column zero.
    assert_cmp_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_cmp_hit |=> !line_cmp_hit);

    assert_cmp_col_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_cmp_hit |-> (pix_col == '0));

    // R11: reset returns the raster to the origin.
    assert_reset_origin_R11: assert property (@(posedge clk)
        !rst_n |=> (pix_col == '0 && pix_line == '0));

endmodule

bind crtc_timing_gen crtc_timing_gen_chk #(
    .COL_W  (COL_W),
    .LINE_W (LINE_W),
    .CHAR_W (CHAR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hsync        (hsync),
    .vsync        (vsync),
    .hblank       (hblank),
    .vblank       (vblank),
    .disp_en      (disp_en),
    .pix_col      (pix_col),
    .pix_line     (pix_line),
    .line_cmp_hit (line_cmp_hit)
);

// File: tb/crtc_timing_gen_tb.sv
// Bench: sweeps every pixel of whole frames for small timing configurations
// and compares each output against values computed from the requirements.
module crtc_timing_gen_tb;

    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  htotal, hdisp_end, hblank_start, hsync_start;
    logic [5:0]  hblank_end;
    logic [4:0]  hsync_end;
    logic [11:0] vtotal, vdisp_end, vblank_start, vsync_start, line_cmp;
    logic [7:0]  vblank_end;
    logic [3:0]  vsync_end;
    logic        hneg, vneg, hoff, voff, scr_off;
    logic        hsync, vsync, hblank, vblank, disp_en, line_cmp_hit;
    logic [12:0] pix_col, pix_line;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    // expected configuration (the one the current frame runs on)
    int e_htot, e_hde, e_hbs, e_hbe, e_hss, e_hse;
    int e_vtot, e_vde, e_vbs, e_vbe, e_vss, e_vse, e_lcmp;
    bit e_hneg, e_vneg, e_hoff, e_voff, e_scr;
    int n = 0;
    int flen = 1;
    int err_geom, err_hb, err_hs, err_vb, err_vs, err_de, err_lc;
    bit shown;

    always #4 clk = ~clk;

    crtc_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_htotal(htotal), .cfg_hdisp_end(hdisp_end), .cfg_hblank_start(hblank_start),
        .cfg_hblank_end(hblank_end), .cfg_hsync_start(hsync_start), .cfg_hsync_end(hsync_end),
        .cfg_vtotal(vtotal), .cfg_vdisp_end(vdisp_end), .cfg_vblank_start(vblank_start),
        .cfg_vblank_end(vblank_end), .cfg_vsync_start(vsync_start), .cfg_vsync_end(vsync_end),
        .cfg_line_cmp(line_cmp),
        .cfg_hsync_neg(hneg), .cfg_vsync_neg(vneg), .cfg_hsync_off(hoff),
        .cfg_vsync_off(voff), .cfg_screen_off(scr_off),
        .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
        .disp_en(disp_en), .pix_col(pix_col), .pix_line(pix_line),
        .line_cmp_hit(line_cmp_hit)
    );

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            summary();
        end
    end

    task automatic check(bit ok, string tag, longint act, longint exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit inwin(int x, int s, int len);
        return (x >= s) && (x < s + len);
    endfunction

    // Config A: 10 chars x 12 lines, blanks end at the totals.
    task automatic cfg_a();
        htotal = 9'd5;  hdisp_end = 9'd3; hblank_start = 9'd3; hblank_end = 6'd9;
        hsync_start = 9'd5; hsync_end = 5'd7;
        vtotal = 12'd10; vdisp_end = 12'd7; vblank_start = 12'd7; vblank_end = 8'd11;
        vsync_start = 12'd9; vsync_end = 4'd10; line_cmp = 12'd8;
    endtask

    // Config B: 40 chars; hsync end field wraps below its start; blanks end early.
    task automatic cfg_b();
        htotal = 9'd35; hdisp_end = 9'd3; hblank_start = 9'd3; hblank_end = 6'd37;
        hsync_start = 9'd30; hsync_end = 5'd2;
        vtotal = 12'd10; vdisp_end = 12'd7; vblank_start = 12'd7; vblank_end = 8'd9;
        vsync_start = 12'd9; vsync_end = 4'd11; line_cmp = 12'd3;
    endtask

    task automatic latch_exp();
        e_htot = int'(htotal); e_hde = int'(hdisp_end); e_hbs = int'(hblank_start);
        e_hbe = int'(hblank_end); e_hss = int'(hsync_start); e_hse = int'(hsync_end);
        e_vtot = int'(vtotal); e_vde = int'(vdisp_end); e_vbs = int'(vblank_start);
        e_vbe = int'(vblank_end); e_vss = int'(vsync_start); e_vse = int'(vsync_end);
        e_lcmp = int'(line_cmp);
        e_hneg = hneg; e_vneg = vneg; e_hoff = hoff; e_voff = voff; e_scr = scr_off;
        flen = (e_htot + 5) * CW * (e_vtot + 2);
    endtask

    task automatic clear_errs();
        err_geom = 0; err_hb = 0; err_hs = 0; err_vb = 0; err_vs = 0; err_de = 0; err_lc = 0;
        shown = 0;
    endtask

    // compare all outputs with the values derived for raster position n
    task automatic compare();
        int t, px, ch, ln, col;
        bit hb, hs, vb, vs, de, lc;
        bit bad;
        t   = e_htot + 5;
        px  = n % CW;
        ch  = (n / CW) % t;
        ln  = n / (CW * t);
        col = ch * CW + px;
        hb  = inwin(ch, e_hbs + 1, ((e_hbe - (e_hbs + 1)) & 63) + 1) | e_scr;
        hs  = (inwin(ch, e_hss, (e_hse - e_hss) & 31) & !e_hoff) ^ e_hneg;
        vb  = inwin(ln, e_vbs + 1, ((e_vbe - (e_vbs + 1)) & 255) + 1) | e_scr;
        vs  = (inwin(ln, e_vss, (e_vse - e_vss) & 15) & !e_voff) ^ e_vneg;
        de  = !hb && !vb && (ch <= e_hde) && (ln <= e_vde);
        lc  = (ln == e_lcmp) && (col == 0);
        bad = 1'b0;
        if (int'(pix_col) != col || int'(pix_line) != ln) begin err_geom++; bad = 1'b1; end
        if (hblank != hb)       begin err_hb++; bad = 1'b1; end
        if (hsync != hs)        begin err_hs++; bad = 1'b1; end
        if (vblank != vb)       begin err_vb++; bad = 1'b1; end
        if (vsync != vs)        begin err_vs++; bad = 1'b1; end
        if (disp_en != de)      begin err_de++; bad = 1'b1; end
        if (line_cmp_hit != lc) begin err_lc++; bad = 1'b1; end
        if (bad && !shown) begin
            shown = 1'b1;
            $display("  mismatch at col=%0d line=%0d: got hb%0b hs%0b vb%0b vs%0b de%0b lc%0b col%0d line%0d, want hb%0b hs%0b vb%0b vs%0b de%0b lc%0b",
                     col, ln, hblank, hsync, vblank, vsync, disp_en, line_cmp_hit,
                     pix_col, pix_line, hb, hs, vb, vs, de, lc);
        end
    endtask

    task automatic step(int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk);
            n = n + 1;
            if (n == flen) begin
                n = 0;
                latch_exp();
            end
            @(negedge clk);
            compare();
        end
    endtask

    task automatic run_to_frame_end();
        step(flen - n);
    endtask

    initial begin
        cfg_a();
        hneg = 1'b1; vneg = 1'b1; hoff = 1'b0; voff = 1'b0; scr_off = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);

        // R11: reset state with active-low syncs idling high
        check(pix_col == 0,  "R11 reset column", pix_col, 0);
        check(pix_line == 0, "R11 reset line", pix_line, 0);
        check(hsync == 1'b1, "R11 reset hsync inactive", hsync, 1);
        check(vsync == 1'b1, "R11 reset vsync inactive", vsync, 1);
        check(hblank == 1'b0 && vblank == 1'b0, "R11 reset blanks", {hblank, vblank}, 0);

        rst_n = 1'b1;
        n = 0;
        latch_exp();
        clear_errs();
        compare();

        // Scenario 1: config A, active-low syncs, two full frames
        step(2 * flen);
        check(err_geom == 0, "R1 raster position (A)", err_geom, 0);
        check(err_hb == 0,   "R2 horizontal blank window (A)", err_hb, 0);
        check(err_hs == 0,   "R3/R6 hsync window, active low", err_hs, 0);
        check(err_vb == 0,   "R4 vertical blank window (A)", err_vb, 0);
        check(err_vs == 0,   "R5/R6 vsync window, active low", err_vs, 0);
        check(err_de == 0,   "R9 display enable (A)", err_de, 0);
        check(err_lc == 0,   "R10 line compare (A)", err_lc, 0);

        // Scenario 2: mid-frame switch to config B, active-high syncs
        clear_errs();
        step(flen / 2);
        cfg_b();
        hneg = 1'b0; vneg = 1'b0;
        run_to_frame_end();
        check(err_geom == 0 && err_hs == 0 && err_lc == 0,
              "R12 old frame completes with old values", err_geom + err_hs + err_lc, 0);
        clear_errs();
        step(2 * flen);
        check(err_geom == 0, "R1 raster position (B)", err_geom, 0);
        check(err_hb == 0,   "R2 blank ends on low-6 match mid-line", err_hb, 0);
        check(err_hs == 0,   "R3 hsync end field wraps below start", err_hs, 0);
        check(err_vb == 0,   "R4 blank ends on low-8 match mid-frame", err_vb, 0);
        check(err_vs == 0,   "R5 two-line vsync", err_vs, 0);
        check(err_de == 0,   "R9 display enable (B)", err_de, 0);
        check(err_lc == 0,   "R10 line compare (B)", err_lc, 0);
        check(err_hs == 0 && err_vs == 0, "R6 active-high syncs", err_hs + err_vs, 0);

        // Scenario 3: both syncs disabled, one with each polarity
        clear_errs();
        step(flen / 3);
        hoff = 1'b1; voff = 1'b1; vneg = 1'b1;
        run_to_frame_end();
        step(flen);
        check(err_hs == 0, "R7 hsync held inactive low", err_hs, 0);
        check(err_vs == 0, "R7 vsync held inactive high", err_vs, 0);

        // Scenario 4: screen off while timing keeps running
        clear_errs();
        hoff = 1'b0; voff = 1'b0; vneg = 1'b0;
        step(7);
        scr_off = 1'b1;
        run_to_frame_end();
        step(flen);
        check(err_de == 0 && err_hb == 0 && err_vb == 0,
              "R8 blanks forced, display enable low", err_de + err_hb + err_vb, 0);
        check(err_geom == 0 && err_hs == 0 && err_vs == 0,
              "R8 counters and syncs keep running", err_geom + err_hs + err_vs, 0);

        summary();
    end

endmodule